// File: doc/BRIEF.md
# Serial Frame Sync and Byte Deframer

This block sits behind a despreading receiver. The receiver hands it one data bit at a time, each bit qualified by a single-cycle strobe. The block hunts for a frame by sliding a 16-bit window over the incoming bits one position per bit. It locks when the window holds the header 0x09 followed by 0xAF. From that bit on, the byte boundary is fixed, and every eight following bits form a byte, most significant bit first.

Every byte after the header is passed out on a byte strobe. The block also walks the frame layout behind the header: an address byte, then a length byte, then that many payload bytes, then a check byte. A frame is accepted only if it is addressed to the local station and its check byte matches. The block raises a one-cycle good-frame or bad-frame pulse and then goes back to hunting for the header. Interpreting the payload is left to the logic downstream.

Top module: `frame_deframer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `byte_stb`, `frame_ok` and `frame_err` are 0.
- R2: In hunt mode, each strobed bit is shifted into a 16-bit window. The frame starts on the strobed bit that makes the most recent 16 bits equal 0x09AF, with the oldest bit as the MSB. Any number of leading bits, at any bit offset, may come before the header.
- R3: A run of idle ones of any length produces no byte strobe and no frame result.
- R4: After the header, every eight strobed bits form one byte, the first bit being bit 7. `byte_stb` is high for exactly the one cycle after the clock edge that sampled the eighth bit, with `byte_data` holding the byte. This applies to the address, length, payload and check bytes.
- R5: `bit_in` is only sampled in cycles where `bit_stb` is high. Its value in any other cycle has no effect.
- R6: If the address byte differs from `local_addr`, `frame_err` pulses together with that byte's strobe, and the block returns to hunting.
- R7: If the length byte exceeds `MAX_LEN` (default 32), `frame_err` pulses together with that byte's strobe, and the block returns to hunting. A length equal to `MAX_LEN` is accepted.
- R8: The check byte is compared with the modulo-256 sum of the address, length and payload bytes. On a match, `frame_ok` pulses with the check byte's strobe. On a mismatch, `frame_err` pulses instead. Either way the block returns to hunting.
- R9: A length of 0 makes the byte right after the length byte the check byte.
- R10: The hunt window does not move while a frame is being read, and it starts empty when hunting resumes. Frame bytes that end in 0x09 followed by a further 0xAF therefore do not start a new frame.
- R11: `frame_ok` and `frame_err` are never high in the same cycle. Each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Despread data bit |
| bit_stb | input | 1 | Qualifies `bit_in` for one cycle |
| local_addr | input | 8 | Station address to accept |
| byte_data | output | 8 | Last byte assembled after the header |
| byte_stb | output | 1 | One-cycle pulse marking a new `byte_data` |
| frame_ok | output | 1 | Frame addressed here with a valid check byte |
| frame_err | output | 1 | Frame rejected for address, length or check |

## Verification
Every result is due exactly one cycle after the clock edge that samples the strobed bit that completes it. The header match moves the block into framing at that edge. `byte_stb`, `frame_ok` and `frame_err` appear in the cycle after the edge that sampled a byte's eighth bit. The behavioural model in the bench advances at the same edges from the same sampled inputs. It is compared with all four outputs at every falling edge, so any slip of one cycle shows up as a mismatch. Per-scenario counts of good and bad pulses also tie each case to its requirement. In every case the strobes are spaced apart and `bit_in` toggles between them.

// File: rtl/deframer_pkg.sv
package deframer_pkg;

    localparam int SYNC_W = 16;
    localparam int BYTE_W = 8;
    localparam logic [SYNC_W-1:0] SYNC_WORD = 16'h09AF;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_ADDR,
        ST_LEN,
        ST_DATA,
        ST_CHECK
    } df_state_e;

    typedef struct packed {
        df_state_e         state;
        logic [BYTE_W-1:0] sum;
        logic [BYTE_W-1:0] remain;
        logic [BYTE_W-1:0] byte_data;
        logic              byte_stb;
        logic              ok;
        logic              err;
    } df_regs_t;

endpackage

// File: rtl/df_sync_window.sv
module df_sync_window #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    SYNC = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift_en,
    input  logic bit_in,
    output logic match
);
    logic [W-1:0] win_d, win_q;
    logic [W-1:0] win_next;

    assign win_next = {win_q[W-2:0], bit_in};

    always_comb begin
        win_d = win_q;
        if (clear) begin
            win_d = '0;
        end else if (shift_en) begin
            win_d = win_next;
        end
    end

    // Match is reported in the strobe cycle so the caller can leave hunt at the same edge.
    assign match = shift_en && !clear && (win_next == SYNC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end
endmodule

// File: rtl/df_byte_packer.sv
module df_byte_packer #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic          done,
    output logic [BW-1:0] data
);
    localparam int CW = (BW > 1) ? $clog2(BW) : 1;
    localparam logic [CW-1:0] LAST = CW'(BW - 1);

    logic [BW-2:0] sr_d, sr_q;
    logic [CW-1:0] cnt_d, cnt_q;

    assign done = shift_en && (cnt_q == LAST);
    assign data = {sr_q, bit_in};

    always_comb begin
        sr_d  = sr_q;
        cnt_d = cnt_q;
        if (clear) begin
            sr_d  = '0;
            cnt_d = '0;
        end else if (shift_en) begin
            sr_d  = data[BW-2:0];
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else begin
            sr_q  <= sr_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/frame_deframer.sv
module frame_deframer
    import deframer_pkg::*;
#(
    parameter int MAX_LEN = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_in,
    input  logic       bit_stb,
    input  logic [7:0] local_addr,
    output logic [7:0] byte_data,
    output logic       byte_stb,
    output logic       frame_ok,
    output logic       frame_err
);
    localparam logic [BYTE_W-1:0] MAX_LEN_B = BYTE_W'(MAX_LEN);

    df_regs_t r_d, r_q;

    logic              in_frame;
    logic              sync_hit;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;

    assign in_frame = (r_q.state != ST_HUNT);

    df_sync_window #(
        .W    (SYNC_W),
        .SYNC (SYNC_WORD)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (in_frame),
        .shift_en (bit_stb && !in_frame),
        .bit_in   (bit_in),
        .match    (sync_hit)
    );

    df_byte_packer #(
        .BW (BYTE_W)
    ) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!in_frame),
        .shift_en (bit_stb && in_frame),
        .bit_in   (bit_in),
        .done     (byte_done),
        .data     (byte_val)
    );

    always_comb begin
        r_d          = r_q;
        r_d.byte_stb = 1'b0;
        r_d.ok       = 1'b0;
        r_d.err      = 1'b0;
        if (!in_frame) begin
            if (sync_hit) begin
                r_d.state = ST_ADDR;
                r_d.sum   = '0;
            end
        end else if (byte_done) begin
            r_d.byte_stb  = 1'b1;
            r_d.byte_data = byte_val;
            unique case (r_q.state)
                ST_ADDR: begin
                    if (byte_val != local_addr) begin
                        r_d.err   = 1'b1;
                        r_d.state = ST_HUNT;
                    end else begin
                        r_d.sum   = byte_val;
                        r_d.state = ST_LEN;
                    end
                end
                ST_LEN: begin
                    if (byte_val > MAX_LEN_B) begin
                        r_d.err   = 1'b1;
                        r_d.state = ST_HUNT;
                    end else begin
                        r_d.sum    = r_q.sum + byte_val;
                        r_d.remain = byte_val;
                        r_d.state  = (byte_val == '0) ? ST_CHECK : ST_DATA;
                    end
                end
                ST_DATA: begin
                    r_d.sum    = r_q.sum + byte_val;
                    r_d.remain = r_q.remain - 1'b1;
                    if (r_q.remain == BYTE_W'(1)) begin
                        r_d.state = ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (byte_val == r_q.sum) begin
                        r_d.ok = 1'b1;
                    end else begin
                        r_d.err = 1'b1;
                    end
                    r_d.state = ST_HUNT;
                end
                default: r_d.state = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_data = r_q.byte_data;
    assign byte_stb  = r_q.byte_stb;
    assign frame_ok  = r_q.ok;
    assign frame_err = r_q.err;
endmodule

// File: rtl/frame_deframer_chk.sv
module frame_deframer_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_stb,
    input logic byte_stb,
    input logic frame_ok,
    input logic frame_err
);
    a_r11_ok_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ok && frame_err));

    a_r11_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> !frame_ok);

    a_r11_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    a_r4_byte_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> $past(bit_stb));

    a_r8_ok_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> byte_stb);

    a_r6_err_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> byte_stb);
endmodule

bind frame_deframer frame_deframer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .byte_stb  (byte_stb),
    .frame_ok  (frame_ok),
    .frame_err (frame_err)
);

// File: tb/tb_frame_deframer.sv
module tb_frame_deframer;
    localparam int MAX_LEN = 32;
    localparam logic [7:0] LOCAL = 8'h05;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_stb = 1'b0;
    logic [7:0] local_addr = LOCAL;
    logic [7:0] byte_data;
    logic       byte_stb, frame_ok, frame_err;

    always #2 clk = ~clk;

    frame_deframer #(.MAX_LEN(MAX_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_stb(bit_stb),
        .local_addr(local_addr), .byte_data(byte_data), .byte_stb(byte_stb),
        .frame_ok(frame_ok), .frame_err(frame_err)
    );

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    int    n_ok = 0, n_err = 0, n_stb = 0;

    // Behavioural reference model
    int         m_phase = 0;
    logic [15:0] m_win = '0;
    bit         m_bits[$];
    int         m_sum = 0, m_left = 0;
    logic [7:0] e_byte = '0;
    bit         e_stb = 0, e_ok = 0, e_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_win = '0; m_bits.delete();
            e_stb = 0; e_ok = 0; e_err = 0; e_byte = '0;
        end else begin
            e_stb = 0; e_ok = 0; e_err = 0;
            if (bit_stb) begin
                if (m_phase == 0) begin
                    m_win = {m_win[14:0], bit_in};
                    if (m_win == 16'h09AF) begin
                        m_phase = 1; m_win = '0; m_bits.delete(); m_sum = 0;
                    end
                end else begin
                    m_bits.push_back(bit_in);
                    if (m_bits.size() == 8) begin
                        int v;
                        v = 0;
                        foreach (m_bits[i]) v = v * 2 + int'(m_bits[i]);
                        m_bits.delete();
                        e_byte = v[7:0];
                        e_stb = 1;
                        case (m_phase)
                            1: if (v != int'(LOCAL)) begin e_err = 1; m_phase = 0; end
                               else begin m_sum = v; m_phase = 2; end
                            2: if (v > MAX_LEN) begin e_err = 1; m_phase = 0; end
                               else begin
                                   m_sum = (m_sum + v) % 256; m_left = v;
                                   m_phase = (v == 0) ? 4 : 3;
                               end
                            3: begin
                                m_sum = (m_sum + v) % 256; m_left--;
                                if (m_left == 0) m_phase = 4;
                            end
                            default: begin
                                if (v == m_sum) e_ok = 1; else e_err = 1;
                                m_phase = 0;
                            end
                        endcase
                    end
                end
            end
        end
    end

    task automatic chk(input bit cond, input string what, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(byte_stb == e_stb, "byte_stb", byte_stb, e_stb);
            chk(frame_ok == e_ok, "frame_ok", frame_ok, e_ok);
            chk(frame_err == e_err, "frame_err", frame_err, e_err);
            if (e_stb) chk(byte_data == e_byte, "byte_data", byte_data, e_byte);
            n_ok  += int'(frame_ok);
            n_err += int'(frame_err);
            n_stb += int'(byte_stb);
        end
    end

    task automatic send_bit(input bit b, input int gap);
        @(negedge clk);
        bit_in = b; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0; bit_in = ~b;
        repeat (gap) begin
            @(negedge clk);
            bit_in = ~bit_in;
        end
    endtask

    task automatic send_byte(input logic [7:0] v, input int gap);
        for (int i = 7; i >= 0; i--) send_bit(v[i], gap);
    endtask

    task automatic send_frame(input logic [7:0] q[$], input int gap);
        send_byte(8'h09, gap);
        send_byte(8'hAF, gap);
        foreach (q[i]) send_byte(q[i], gap);
    endtask

    function automatic logic [7:0] csum(input logic [7:0] q[$]);
        logic [7:0] s;
        s = '0;
        foreach (q[i]) s = s + q[i];
        return s;
    endfunction

    task automatic expect_counts(input string req, input int ok0, input int err0,
                                 input int want_ok, input int want_err);
        repeat (4) @(negedge clk);
        cur_req = req;
        chk(n_ok - ok0 == want_ok, "frame_ok count", n_ok - ok0, want_ok);
        chk(n_err - err0 == want_err, "frame_err count", n_err - err0, want_err);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] q[$];
        int o, e, s;
        // R1: reset state
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(byte_stb == 0, "byte_stb in reset", byte_stb, 0);
        chk(frame_ok == 0, "frame_ok in reset", frame_ok, 0);
        chk(frame_err == 0, "frame_err in reset", frame_err, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        chk(byte_stb == 0 && frame_ok == 0 && frame_err == 0, "outputs after reset", 0, 0);

        // R3: long idle ones
        cur_req = "R3"; o = n_ok; e = n_err; s = n_stb;
        for (int i = 0; i < 48; i++) send_bit(1'b1, 0);
        expect_counts("R3", o, e, 0, 0);
        chk(n_stb == s, "byte_stb count on idle", n_stb - s, 0);

        // R2 R4 R8: good frame after odd preamble, no gaps
        cur_req = "R2"; o = n_ok; e = n_err;
        for (int i = 0; i < 7; i++) send_bit(1'b1, 0);
        q = '{LOCAL, 8'h03, 8'h11, 8'h22, 8'h33};
        q.push_back(csum(q));
        send_frame(q, 0);
        expect_counts("R8", o, e, 1, 0);

        // R5: junk bits, strobe gaps with toggling bit_in
        cur_req = "R5"; o = n_ok; e = n_err;
        send_bit(1, 3); send_bit(0, 3); send_bit(1, 3); send_bit(1, 3); send_bit(0, 3);
        q = '{LOCAL, 8'h02, 8'hF0, 8'h0F};
        q.push_back(csum(q));
        send_frame(q, 3);
        expect_counts("R5", o, e, 1, 0);

        // R6: foreign address
        cur_req = "R6"; o = n_ok; e = n_err;
        q = '{8'h06, 8'h01, 8'h44, 8'h4B};
        send_frame(q, 1);
        expect_counts("R6", o, e, 0, 1);

        // R7: length one above the limit, then exactly at the limit
        cur_req = "R7"; o = n_ok; e = n_err;
        q = '{LOCAL, 8'(MAX_LEN + 1)};
        send_frame(q, 1);
        expect_counts("R7", o, e, 0, 1);
        o = n_ok; e = n_err;
        q = '{LOCAL, 8'(MAX_LEN)};
        for (int i = 0; i < MAX_LEN; i++) q.push_back(8'(i * 7 + 1));
        q.push_back(csum(q));
        send_frame(q, 0);
        expect_counts("R7", o, e, 1, 0);

        // R8: wrong check byte
        cur_req = "R8"; o = n_ok; e = n_err;
        q = '{LOCAL, 8'h01, 8'h10};
        q.push_back(csum(q) + 8'h01);
        send_frame(q, 1);
        expect_counts("R8", o, e, 0, 1);

        // R9: zero length
        cur_req = "R9"; o = n_ok; e = n_err;
        q = '{LOCAL, 8'h00, 8'h05};
        send_frame(q, 2);
        expect_counts("R9", o, e, 1, 0);

        // R10: check byte 0x09 followed by 0xAF must not resync
        cur_req = "R10"; o = n_ok; e = n_err;
        q = '{LOCAL, 8'h01, 8'h03, 8'h09};
        send_frame(q, 1);
        send_byte(8'hAF, 1);
        send_byte(LOCAL, 1);
        send_byte(8'h00, 1);
        send_byte(LOCAL, 1);
        expect_counts("R10", o, e, 1, 0);

        // R11: every result above was a single pulse; check total balance
        cur_req = "R11";
        chk(n_ok == 5, "total frame_ok pulses", n_ok, 5);
        chk(n_err == 3, "total frame_err pulses", n_err, 3);

        repeat (5) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule